// File: doc/BRIEF.md
# Averaging Nearest-Level Arm Modulator

This block converts a voltage reference for one converter arm into on/off commands for the arm's submodules. The reference is an unsigned fixed-point number whose unit is one capacitor voltage: the upper bits give a whole number of levels and the lower bits a fraction of a level. The block works in fixed pulse periods of `2**CNT_W` clock cycles. At each period boundary it captures the reference. The integer part sets how many submodules stay fully on for the whole period. The fraction sets the duty cycle of one extra submodule, which is switched by comparing a free-running counter against the fraction scaled to the period length. Over a period, the mean inserted level then equals the reference.

The extra, pulse-width-modulated submodule is chosen by a ring pointer that moves one place every period, so the switching duty is spread over all submodules. The fully inserted submodules are always the ones that follow the pointer around the ring, so the switched submodule is never one of them. A parameter selects a plain rounding variant instead, which has no switched submodule and inserts the nearest whole level.

Top module: `avg_nlm_modulator`

## Requirements
- R1: While reset is high and through the whole first period after reset, `on_o` is all zero and `slot_o` is 0.
- R2: A period lasts `2**CNT_W` cycles (16 by default). The reference is captured only at the clock edge that ends a period, and a change to `ref_i` at any other time does not affect `on_o` or `slot_o` until the next period.
- R3: The integer part `ref_i[REF_W-1:FRAC_W]` gives the number of submodules held on for the whole period.
- R4: The switched submodule is on during the first `frac * 2**(CNT_W-FRAC_W)` cycles of a period and off for the remaining cycles, where `frac = ref_i[FRAC_W-1:0]`. A zero fraction means it is never on.
- R5: `slot_o` starts at 0, becomes 1 after the first period boundary, and then advances by one modulo `N_SM` at every period boundary.
- R6: With integer part `n < N_SM`, the submodules held on are those at ring positions `(slot_o+1+i) mod N_SM` for `i = 0..n-1`. The submodule at `slot_o` is never one of them.
- R7: An integer part of `N_SM` or more turns all `N_SM` submodules on for the period and ignores the fraction.
- R8: With `MODE = MOD_ROUND`, the number of submodules on is `min(int + frac[FRAC_W-1], N_SM)` for the whole period, and no submodule is switched within the period.
- R9: In every cycle the number of submodules on is either the captured whole count or that count plus one.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_i | input | REF_W | Arm reference in capacitor-voltage units, FRAC_W fractional bits |
| on_o | output | N_SM | Insertion command, one bit per submodule, 1 = inserted |
| slot_o | output | SLOT_W | Index of the submodule assigned to pulse-width modulation |

## Verification
At every period boundary, three things happen in the same cycle: the new reference is captured, the ring pointer moves, and the switched submodule turns on because the counter is back at zero. A wrong ordering of these would show up as a stale mask, a stale slot or a late pulse edge. The bench provokes this by loading a new value into `ref_i` right after each boundary, so the period under test still runs on the value captured before. It then compares `on_o` and `slot_o` in every cycle of the period against an expected item built from the requirements. Fractions are chosen so that the pulse edge falls early, late and not at all. Vectors near full scale cover the case where the switched submodule is the only one left off, and the case where the fraction has to be dropped.

// File: rtl/amod_pkg.sv
package amod_pkg;

    // Variant picked at elaboration: averaging with one switched submodule,
    // or plain rounding to the nearest whole level.
    typedef enum logic {
        MOD_AVG   = 1'b0,
        MOD_ROUND = 1'b1
    } mod_mode_e;

    // Ring distance from pointer s to position j, counting the first
    // position after s as 0. The pointer itself lands at ring_len-1.
    function automatic int unsigned ring_dist(
        input int unsigned j,
        input int unsigned s,
        input int unsigned ring_len
    );
        return (j > s) ? (j - s - 1) : (j + ring_len - s - 1);
    endfunction

    // Saturating clamp of a whole-level count to the number of submodules.
    function automatic int unsigned clamp_count(
        input int unsigned cnt,
        input int unsigned limit
    );
        return (cnt >= limit) ? limit : cnt;
    endfunction

endpackage

// File: rtl/amod_period_cnt.sv
module amod_period_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt_o,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o  = cnt_q;
    assign last_o = (cnt_q == {CNT_W{1'b1}});

    // R2: the counter steps by one inside a period
    assert_cnt_step_R2: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0) |-> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/amod_level_latch.sv
module amod_level_latch
    import amod_pkg::*;
#(
    parameter mod_mode_e MODE   = MOD_AVG,
    parameter int        N_SM   = 6,
    parameter int        FRAC_W = 3,
    parameter int        INT_W  = 3,
    localparam int       REF_W  = INT_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [REF_W-1:0]  ref_i,
    output logic [INT_W-1:0]  full_o,
    output logic [FRAC_W-1:0] frac_o
);
    logic [INT_W-1:0]  int_part;
    logic [FRAC_W-1:0] frac_part;
    logic [INT_W-1:0]  full_d;
    logic [FRAC_W-1:0] frac_d;
    logic [INT_W-1:0]  full_q;
    logic [FRAC_W-1:0] frac_q;

    assign int_part  = ref_i[REF_W-1:FRAC_W];
    assign frac_part = ref_i[FRAC_W-1:0];

    generate
        if (MODE == MOD_AVG) begin : g_avg
            always_comb begin
                if (32'(int_part) >= N_SM) begin
                    full_d = INT_W'(N_SM);
                    frac_d = '0;
                end else begin
                    full_d = int_part;
                    frac_d = frac_part;
                end
            end
        end else begin : g_round
            logic [INT_W:0] sum;
            assign sum = {1'b0, int_part} + {{INT_W{1'b0}}, frac_part[FRAC_W-1]};
            always_comb begin
                full_d = INT_W'(clamp_count(32'(sum), N_SM));
                frac_d = '0;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= '0;
            frac_q <= '0;
        end else if (load_i) begin
            full_q <= full_d;
            frac_q <= frac_d;
        end
    end

    assign full_o = full_q;
    assign frac_o = frac_q;

    // R2: the captured level never changes inside a period
    assert_level_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> ($stable(full_q) && $stable(frac_q)));
    // R7: full scale never carries a fraction
    assert_full_nofrac_R7: assert property (@(posedge clk) disable iff (rst)
        (32'(full_q) == N_SM) |-> (frac_q == '0));
    // R3: whole count never exceeds the submodule count
    assert_full_range_R3: assert property (@(posedge clk) disable iff (rst)
        32'(full_q) <= N_SM);
endmodule

// File: rtl/amod_slot_ring.sv
module amod_slot_ring
    import amod_pkg::*;
#(
    parameter int  N_SM   = 6,
    parameter int  INT_W  = 3,
    localparam int SLOT_W = (N_SM > 1) ? $clog2(N_SM) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [INT_W-1:0]  full_i,
    output logic [SLOT_W-1:0] slot_o,
    output logic [N_SM-1:0]   mask_o
);
    logic [SLOT_W-1:0] slot_q;

    always_ff @(posedge clk) begin
        if (rst)
            slot_q <= '0;
        else if (load_i)
            slot_q <= (32'(slot_q) == N_SM - 1) ? '0 : slot_q + 1'b1;
    end

    // Fully inserted submodules occupy the ring positions that follow the
    // pointer; the pointer position only fills when every submodule is on.
    generate
        for (genvar j = 0; j < N_SM; j++) begin : g_mask
            assign mask_o[j] = ring_dist(j, 32'(slot_q), N_SM) < 32'(full_i);
        end
    endgenerate

    assign slot_o = slot_q;

    // R5: pointer stays inside the ring
    assert_slot_range_R5: assert property (@(posedge clk) disable iff (rst)
        32'(slot_q) < N_SM);
    // R5: pointer moves at every boundary
    assert_slot_moves_R5: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (slot_q != $past(slot_q)));
    // R5: pointer holds inside a period
    assert_slot_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(slot_q));
endmodule

// File: rtl/avg_nlm_modulator.sv
module avg_nlm_modulator
    import amod_pkg::*;
#(
    parameter mod_mode_e MODE   = MOD_AVG,
    parameter int        N_SM   = 6,
    parameter int        FRAC_W = 3,
    parameter int        CNT_W  = 4,
    localparam int       INT_W  = $clog2(N_SM + 1),
    localparam int       REF_W  = INT_W + FRAC_W,
    localparam int       SLOT_W = (N_SM > 1) ? $clog2(N_SM) : 1,
    localparam int       SHIFT  = CNT_W - FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REF_W-1:0]  ref_i,
    output logic [N_SM-1:0]   on_o,
    output logic [SLOT_W-1:0] slot_o
);
    logic [CNT_W-1:0]  cnt;
    logic              last;
    logic [INT_W-1:0]  full;
    logic [FRAC_W-1:0] frac;
    logic [N_SM-1:0]   mask;
    logic [SLOT_W-1:0] slot;
    logic [CNT_W-1:0]  thr;
    logic              pwm_on;
    logic [N_SM-1:0]   pwm_bit;

    amod_period_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .cnt_o  (cnt),
        .last_o (last)
    );

    amod_level_latch #(
        .MODE   (MODE),
        .N_SM   (N_SM),
        .FRAC_W (FRAC_W),
        .INT_W  (INT_W)
    ) u_lvl (
        .clk    (clk),
        .rst    (rst),
        .load_i (last),
        .ref_i  (ref_i),
        .full_o (full),
        .frac_o (frac)
    );

    amod_slot_ring #(
        .N_SM  (N_SM),
        .INT_W (INT_W)
    ) u_ring (
        .clk    (clk),
        .rst    (rst),
        .load_i (last),
        .full_i (full),
        .slot_o (slot),
        .mask_o (mask)
    );

    // Fraction scaled to the period length: on while the counter is below it.
    assign thr     = CNT_W'(frac) << SHIFT;
    assign pwm_on  = (cnt < thr);
    assign pwm_bit = pwm_on ? (N_SM'(1) << slot) : '0;
    assign on_o    = mask | pwm_bit;
    assign slot_o  = slot;

    // R6: the switched submodule is never among the fully inserted ones
    assert_slot_not_full_R6: assert property (@(posedge clk) disable iff (rst)
        (32'(full) < N_SM) |-> !mask[slot]);
    // R9: inserted count is the whole count or one more
    assert_count_R9: assert property (@(posedge clk) disable iff (rst)
        ($countones(on_o) == 32'(full)) || ($countones(on_o) == 32'(full) + 1));
    // R4: past the duty window only the whole-level submodules are on
    assert_pwm_off_R4: assert property (@(posedge clk) disable iff (rst)
        (cnt >= thr) |-> (on_o == mask));
    // R3: fully inserted count matches the captured whole count
    assert_mask_count_R3: assert property (@(posedge clk) disable iff (rst)
        $countones(mask) == 32'(full));
endmodule

// File: tb/avg_nlm_modulator_bench.sv
module avg_nlm_modulator_bench;
    import amod_pkg::*;

    localparam int N      = 6;
    localparam int FW     = 3;
    localparam int CW     = 4;
    localparam int PER    = 1 << CW;
    localparam int IW     = 3;
    localparam int RW     = IW + FW;
    localparam int SW     = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [RW-1:0] ref_v = '0;
    logic [N-1:0]  on_a, on_r;
    logic [SW-1:0] slot_a, slot_r;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    avg_nlm_modulator #(.MODE(MOD_AVG), .N_SM(N), .FRAC_W(FW), .CNT_W(CW)) u_avg_nlm_modulator (
        .clk(clk), .rst(rst), .ref_i(ref_v), .on_o(on_a), .slot_o(slot_a));

    avg_nlm_modulator #(.MODE(MOD_ROUND), .N_SM(N), .FRAC_W(FW), .CNT_W(CW)) u_avg_nlm_modulator_rnd (
        .clk(clk), .rst(rst), .ref_i(ref_v), .on_o(on_r), .slot_o(slot_r));

    typedef struct {
        int           slot;
        logic [N-1:0] mask;
        int           thr;
        int           nfull;
        int           nrnd;
    } exp_t;

    exp_t sb[$];

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    endtask

    // Expected item for one period, from the requirements only.
    function automatic exp_t build(input int ival, input int fval, input int s);
        exp_t e;
        int n;
        int r;
        n = (ival >= N) ? N : ival;
        e.slot  = s;
        e.nfull = n;
        e.thr   = (ival >= N) ? 0 : fval * (PER >> FW);
        e.mask  = '0;
        for (int i = 0; i < n; i++) e.mask[(s + 1 + i) % N] = 1'b1;
        r = ival + ((fval >= (1 << (FW - 1))) ? 1 : 0);
        e.nrnd = (r >= N) ? N : r;
        return e;
    endfunction

    // Driver: loads a reference for the next period right after a boundary,
    // waits for the boundary that captures it, and queues the expectation.
    initial begin
        int iv [12] = '{0, 2, 2, 3, 5, 6, 7, 0, 4, 1, 5, 3};
        int fv [12] = '{0, 0, 4, 1, 7, 0, 4, 3, 4, 6, 0, 7};
        int s;
        s = 0;
        repeat (3) @(posedge clk);
        for (int v = 0; v < 12; v++) begin
            @(negedge clk);
            rst   = 1'b0;
            ref_v = RW'((iv[v] << FW) | fv[v]);
            repeat (PER) @(posedge clk);
            s = (s + 1) % N;
            sb.push_back(build(iv[v], fv[v], s));
        end
        repeat (PER + 4) @(negedge clk);
        done = 1'b1;
        finish_run();
    end

    // Reset state and the idle first period (R1).
    initial begin
        @(negedge clk);
        chk(on_a == '0, "R1 on_o in reset", int'(on_a), 0);
        chk(slot_a == '0, "R1 slot_o in reset", int'(slot_a), 0);
        wait (rst == 1'b0);
        for (int k = 0; k < PER - 1; k++) begin
            @(negedge clk);
            chk(on_a == '0, "R1 on_o first period", int'(on_a), 0);
            chk(slot_a == '0, "R1 slot_o first period", int'(slot_a), 0);
        end
    end

    // Monitor: pops one expectation per period and compares every cycle.
    initial begin
        exp_t  e;
        logic [N-1:0] want;
        string tag;
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                e = sb.pop_front();
                for (int k = 0; k < PER; k++) begin
                    if (k > 0) @(negedge clk);
                    want = e.mask;
                    if (k < e.thr) want[e.slot] = 1'b1;
                    if (e.nfull == N)   tag = "R7 all on";
                    else if (k < e.thr) tag = "R4 pwm window R3 R6";
                    else                tag = "R6 whole levels R3 R4";
                    // ref_i already holds the next value from k=0 on: R2
                    if (k > 0) tag = {tag, " R2"};
                    chk(on_a == want, tag, int'(on_a), int'(want));
                    chk(32'(slot_a) == e.slot, "R5 slot", int'(slot_a), e.slot);
                    if (k == 0) begin
                        chk(($countones(on_a) == e.nfull) ||
                            ($countones(on_a) == e.nfull + 1),
                            "R9 count", $countones(on_a), e.nfull);
                    end
                    if (k == 0 || k == PER - 1) begin
                        chk($countones(on_r) == e.nrnd, "R8 rounding count",
                            $countones(on_r), e.nrnd);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            finish_run();
        end
    end
endmodule